// File: doc/BRIEF.md
# Periodic Cycle Timer with Sync Pulse Generator

This block keeps a free-running cycle counter that sets the period of a control loop. When the counter reaches the period compare value, it returns to zero on the next clock and raises a one-cycle event strobe that can start a firmware task. A second compare value places a point inside each cycle. At that point a single-cycle strobe is raised and, if the sync output is armed, a sync pulse of programmable width is started. With the defaults and a 200 MHz clock, the period is 12500 cycles (62.5 us) and the pulse is 10 cycles (50 ns).

The sync output has two modes. In continuous mode it fires once in every cycle. In single-shot mode it fires once and then stays quiet. Firmware re-arms it by clearing the sync enable and setting it again, usually inside the task started by the period event. The sync pulse is controlled by a four-state machine:

- **SY_OFF**: the sync output is disabled.
- **SY_ARMED**: the block waits for the in-cycle compare strobe.
- **SY_PULSE**: the pulse is being driven.
- **SY_SPENT**: a single-shot pulse has been used up.

The transitions are:

- **OFF->ARMED**: the enable is seen set.
- **ARMED->PULSE**: the compare strobe is seen while armed.
- **PULSE->ARMED**: the width has elapsed in continuous mode.
- **PULSE->SPENT**: the width has elapsed in single-shot mode.
- **SPENT->SPENT**: the block holds there while the enable stays set.
- **any->OFF**: the enable is seen clear. This transition has the highest priority.

Top module: `cyc_sync_timer`

## Requirements
- R1: After reset, `sync_out`, `cmp0_evt` and `cmp1_evt` are low. The timer is stopped and the sync output is disabled. The reset values are: period compare 12499, sync compare 0, width 10, control 0.
- R2: While running, the counter counts 0,1,...,P and then 0 again, where P is the period compare value. `cmp0_evt` is high for exactly the one cycle after the counter held P, so the period is P+1 cycles.
- R3: While running, `cmp1_evt` is high for the one cycle after the counter held the sync compare value. If that value is larger than P, `cmp1_evt` never fires.
- R4: When `cmp1_evt` is high while the FSM is in SY_ARMED, `sync_out` rises in the next cycle and stays high for W cycles, where W is the width value. A width of 0 gives a 1-cycle pulse.
- R5: In single-shot mode, the FSM goes to SY_SPENT after one pulse, and no further pulse occurs while the enable stays set.
- R6: Clearing the sync enable for at least one clock and then setting it again re-arms the output, so the next compare strobe produces a pulse.
- R7: In continuous mode, the FSM returns to SY_ARMED after each pulse, giving one pulse per timer cycle.
- R8: A write that clears the sync enable makes `sync_out` low no later than the second clock edge after the write edge, cutting a pulse short.
- R9: A compare strobe that arrives while the FSM is in SY_OFF, SY_SPENT or SY_PULSE starts no pulse.
- R10: While the run bit is clear, the counter is held at zero and neither strobe fires.
- R11: A write with `wr_en` high stores `wr_data` at the clock edge, and the new value is used from the next cycle. The `wr_sel` values are:
  - 0: period compare.
  - 1: sync compare.
  - 2: width (low bits).
  - 3: control, where bit 0 is run, bit 1 is sync enable, and bit 2 selects single-shot mode (1) or continuous mode (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 period, 1 sync compare, 2 width, 3 control) |
| wr_data | input | CNT_W | Write data |
| sync_out | output | 1 | Sync pulse |
| cmp0_evt | output | 1 | One-cycle period (wrap) event |
| cmp1_evt | output | 1 | One-cycle in-cycle compare event |

## Verification
The sync machine is driven through several patterns:

- **Single-shot with no re-arm.** This separates a correct SY_SPENT hold from a machine that keeps re-firing.
- **Single-shot with a disable/enable toggle.** This shows that re-arming is possible.
- **Continuous mode over a window aligned to the period event.** This must count exactly one pulse per cycle.
- **Widths of 3 and 0.** These tell the W-cycle rule apart from an off-by-one and test the zero-width floor.
- **A disable during a wide pulse.** This tests that a pulse can be cut short.
- **A sync compare beyond the period, and a stopped timer.** These confirm that the strobes stay silent.

A behavioural model predicts all three outputs on every clock.

// File: rtl/cst_pkg.sv
package cst_pkg;
    typedef enum logic [1:0] {
        SY_OFF   = 2'd0,
        SY_ARMED = 2'd1,
        SY_PULSE = 2'd2,
        SY_SPENT = 2'd3
    } sync_st_e;

    localparam logic [1:0] SEL_PERIOD = 2'd0;
    localparam logic [1:0] SEL_SYNCCMP = 2'd1;
    localparam logic [1:0] SEL_WIDTH  = 2'd2;
    localparam logic [1:0] SEL_CTRL   = 2'd3;

    localparam int CTRL_RUN_BIT    = 0;
    localparam int CTRL_EN_BIT     = 1;
    localparam int CTRL_SINGLE_BIT = 2;
endpackage

// File: rtl/cst_counter.sv
module cst_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] period_val,
    input  logic [CNT_W-1:0] sync_cmp_val,
    output logic             wrap_evt,
    output logic             hit_evt
);
    logic [CNT_W-1:0] cnt_q;
    logic             at_end;
    logic             at_hit;

    always_comb begin
        at_end = (cnt_q == period_val);
        at_hit = (cnt_q == sync_cmp_val);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            wrap_evt <= 1'b0;
            hit_evt  <= 1'b0;
        end else if (!run) begin
            cnt_q    <= '0;
            wrap_evt <= 1'b0;
            hit_evt  <= 1'b0;
        end else begin
            cnt_q    <= at_end ? '0 : cnt_q + 1'b1;
            wrap_evt <= at_end;
            hit_evt  <= at_hit;
        end
    end

    // R2
    wrap_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_evt |-> (cnt_q == '0));

    // R10
    stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!wrap_evt && !hit_evt));

    // R10
    stopped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));
endmodule

// File: rtl/cst_sync_fsm.sv
module cst_sync_fsm
    import cst_pkg::*;
#(
    parameter int WID_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_en,
    input  logic             single,
    input  logic [WID_W-1:0] width,
    input  logic             hit_evt,
    output logic             sync_out
);
    sync_st_e         st_q, st_d;
    logic [WID_W-1:0] left_q;

    always_comb begin
        st_d = st_q;
        if (!sync_en) begin
            st_d = SY_OFF;
        end else begin
            unique case (st_q)
                SY_OFF:   st_d = SY_ARMED;
                SY_ARMED: if (hit_evt) st_d = SY_PULSE;
                SY_PULSE: if (left_q == '0) st_d = single ? SY_SPENT : SY_ARMED;
                SY_SPENT: st_d = SY_SPENT;
                default:  st_d = SY_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SY_OFF;
            left_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_d == SY_PULSE && st_q != SY_PULSE)
                left_q <= (width == '0) ? '0 : width - 1'b1;
            else if (st_q == SY_PULSE && left_q != '0)
                left_q <= left_q - 1'b1;
        end
    end

    always_comb begin
        sync_out = (st_q == SY_PULSE);
    end

    // R4
    sync_after_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_out) |-> $past(hit_evt));

    // R5
    spent_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SY_SPENT && sync_en) |=> !sync_out);

    // R8
    disable_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_en |=> !sync_out);
endmodule

// File: rtl/cyc_sync_timer.sv
module cyc_sync_timer
    import cst_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int WID_W      = 8,
    parameter int DEF_PERIOD = 12499,
    parameter int DEF_WIDTH  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic             sync_out,
    output logic             cmp0_evt,
    output logic             cmp1_evt
);
    localparam logic [CNT_W-1:0] PERIOD_RST = CNT_W'(DEF_PERIOD);
    localparam logic [WID_W-1:0] WIDTH_RST  = WID_W'(DEF_WIDTH);

    logic [CNT_W-1:0] period_q;
    logic [CNT_W-1:0] synccmp_q;
    logic [WID_W-1:0] width_q;
    logic             run_q;
    logic             en_q;
    logic             single_q;

    // R11
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q  <= PERIOD_RST;
            synccmp_q <= '0;
            width_q   <= WIDTH_RST;
            run_q     <= 1'b0;
            en_q      <= 1'b0;
            single_q  <= 1'b0;
        end else if (wr_en) begin
            unique case (wr_sel)
                SEL_PERIOD:  period_q  <= wr_data;
                SEL_SYNCCMP: synccmp_q <= wr_data;
                SEL_WIDTH:   width_q   <= wr_data[WID_W-1:0];
                SEL_CTRL: begin
                    run_q    <= wr_data[CTRL_RUN_BIT];
                    en_q     <= wr_data[CTRL_EN_BIT];
                    single_q <= wr_data[CTRL_SINGLE_BIT];
                end
                default: ;
            endcase
        end
    end

    cst_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .run          (run_q),
        .period_val   (period_q),
        .sync_cmp_val (synccmp_q),
        .wrap_evt     (cmp0_evt),
        .hit_evt      (cmp1_evt)
    );

    cst_sync_fsm #(.WID_W(WID_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_en  (en_q),
        .single   (single_q),
        .width    (width_q),
        .hit_evt  (cmp1_evt),
        .sync_out (sync_out)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!sync_out && !cmp0_evt && !cmp1_evt));
endmodule

// File: tb/sim_cyc_sync_timer.sv
module sim_cyc_sync_timer;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        sync_out, cmp0_evt, cmp1_evt;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    cyc_sync_timer u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .sync_out(sync_out), .cmp0_evt(cmp0_evt),
        .cmp1_evt(cmp1_evt)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int m_cnt, m_p0, m_p1, m_w, m_st, m_wc;
    bit m_run, m_en, m_single, m_c0, m_c1;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_p0 = 12499; m_p1 = 0; m_w = 10;
            m_run = 0; m_en = 0; m_single = 0; m_c0 = 0; m_c1 = 0;
            m_st = 0; m_wc = 0;
        end else begin
            int o_cnt, o_p0, o_p1, o_w, o_st, o_wc;
            bit o_run, o_en, o_single, o_c1;
            o_cnt = m_cnt; o_p0 = m_p0; o_p1 = m_p1; o_w = m_w; o_st = m_st;
            o_wc = m_wc; o_run = m_run; o_en = m_en; o_single = m_single; o_c1 = m_c1;
            if (wr_en) begin
                case (wr_sel)
                    2'd0: m_p0 = int'(wr_data);
                    2'd1: m_p1 = int'(wr_data);
                    2'd2: m_w = int'(wr_data) % 256;
                    default: begin
                        m_run = wr_data[0]; m_en = wr_data[1]; m_single = wr_data[2];
                    end
                endcase
            end
            if (!o_run) begin
                m_cnt = 0; m_c0 = 0; m_c1 = 0;
            end else begin
                m_c0 = (o_cnt == o_p0);
                m_c1 = (o_cnt == o_p1);
                m_cnt = (o_cnt == o_p0) ? 0 : (o_cnt + 1) % 65536;
            end
            if (!o_en) m_st = 0;
            else if (o_st == 0) m_st = 1;
            else if (o_st == 1) begin
                if (o_c1) begin m_st = 2; m_wc = (o_w == 0) ? 0 : o_w - 1; end
            end else if (o_st == 2) begin
                if (o_wc == 0) m_st = o_single ? 3 : 1;
                else m_wc = o_wc - 1;
            end
        end
    end

    // per-clock comparison and pulse bookkeeping
    int rises = 0, c0_seen = 0, c1_seen = 0, hi_len = 0, last_len = 0;
    bit prev_sync = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            chk(cmp0_evt == m_c0, "R2 cmp0_evt", cmp0_evt, m_c0);
            chk(cmp1_evt == m_c1, "R3 cmp1_evt", cmp1_evt, m_c1);
            chk(sync_out == (m_st == 2), "R4 sync_out", sync_out, (m_st == 2));
            if (sync_out && !prev_sync) rises++;
            if (cmp0_evt) c0_seen++;
            if (cmp1_evt) c1_seen++;
            if (sync_out) hi_len++;
            else if (prev_sync) begin last_len = hi_len; hi_len = 0; end
            prev_sync = sync_out;
        end
    end

    // R11: register write, held for one clock
    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        int base, base1, t0;
        wait_cyc(3);
        // R1
        chk(!sync_out && !cmp0_evt && !cmp1_evt, "R1 reset outputs", {sync_out, cmp0_evt, cmp1_evt}, 0);
        rst_n = 1'b1;
        wait_cyc(20);
        // R10: still stopped after reset
        chk(c0_seen == 0 && c1_seen == 0, "R10 stopped after reset", c0_seen + c1_seen, 0);

        wr(2'd0, 16'd19);
        wr(2'd1, 16'd5);
        wr(2'd2, 16'd3);
        wr(2'd3, 16'b111);
        base = rises;
        wait_cyc(100);
        // R5
        chk(rises - base == 1, "R5 single-shot once", rises - base, 1);
        // R4
        chk(last_len == 3, "R4 width 3", last_len, 3);

        // R6
        wr(2'd3, 16'b101);
        wr(2'd3, 16'b111);
        base = rises;
        wait_cyc(60);
        chk(rises - base == 1, "R6 re-arm after toggle", rises - base, 1);

        // R7
        wr(2'd3, 16'b001);
        wr(2'd3, 16'b011);
        @(negedge clk);
        while (!cmp0_evt) @(negedge clk);
        base = rises;
        wait_cyc(100);
        chk(rises - base == 5, "R7 continuous one per cycle", rises - base, 5);

        // R4 zero width
        wr(2'd2, 16'd0);
        wait_cyc(60);
        chk(last_len == 1, "R4 zero width", last_len, 1);

        // R8
        wr(2'd2, 16'd8);
        @(negedge clk);
        while (!sync_out) @(negedge clk);
        wr(2'd3, 16'b001);
        @(negedge clk);
        chk(sync_out == 1'b0, "R8 disable cuts pulse", sync_out, 0);
        chk(last_len < 8, "R8 shortened pulse", last_len, 8);

        // R9: not armed
        base = rises; base1 = c1_seen;
        wait_cyc(60);
        chk(rises - base == 0, "R9 no pulse when off", rises - base, 0);
        chk(c1_seen - base1 >= 2, "R9 strobes still present", c1_seen - base1, 3);

        // R3: compare beyond period
        wr(2'd1, 16'd30);
        wait_cyc(3);
        base1 = c1_seen;
        wait_cyc(60);
        chk(c1_seen - base1 == 0, "R3 compare beyond period", c1_seen - base1, 0);

        // R11 / R2: new period of 10 cycles
        wr(2'd0, 16'd9);
        @(negedge clk);
        while (!cmp0_evt) @(negedge clk);
        t0 = 0;
        @(negedge clk); t0++;
        while (!cmp0_evt) begin @(negedge clk); t0++; end
        chk(t0 == 10, "R11 R2 new period spacing", t0, 10);

        // R10: stop
        wr(2'd3, 16'b000);
        wait_cyc(2);
        base = c0_seen; base1 = c1_seen;
        wait_cyc(50);
        chk(c0_seen == base && c1_seen == base1, "R10 stopped no events",
            (c0_seen - base) + (c1_seen - base1), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule